// File: doc/BRIEF.md
# Two-Channel Indirect Configuration Register Front End

This block is the I/O-mapped configuration front end of a two-channel disk host controller. Software reaches it through two port offsets on a simple synchronous bus. Offset 1 is a byte-wide pointer register. Offset 0 is a word-wide data port that reads or writes one entry in one of two banks of seven configuration registers. The pointer's channel bit chooses the bank, and its three-bit index field chooses the entry.

When the pointer's auto-increment bit is set, the index steps forward after every data-port access. Software can then stream a whole bank through the data port without rewriting the pointer. Every stored field is driven out continuously to the drive timing and control logic. This includes the bus-behaviour bits held in the pointer itself.

Top module: `cfgfe_top`

## Requirements
- R1: After reset the pointer reads back at offset 1 as 0x50. Its bit fields are: bit 7 auto-increment, bit 6 posted-write wait state, bit 5 burst disable, bit 4 medium select timing, bit 3 channel, bits 2-0 index.
- R2: A data-port access at offset 0 targets the bank chosen by pointer bit 3 (0 = channel 0, 1 = channel 1) and the entry chosen by pointer bits 2-0.
- R3: With pointer bit 7 set, the index increments by one on the edge that ends each data-port read or write. With bit 7 clear, the index does not change.
- R4: Auto-increment wraps the index from 6 (and from 7) back to 0.
- R5: Reset values are as follows. Entry 0 (command base) is 0x01F0 on channel 0 and 0x0170 on channel 1. Entry 4 (control base) is 0x03F6 on channel 0 and 0x0376 on channel 1. Entry 1 (general config) is 0x01. Entry 5 (data timing) is 0xF5. Entry 6 (command timing) is 0xDE. Entries 2 and 3 reset to zero.
- R6: Entries 2 and 3 are write-only and read as zero. Entry 2 holds count bits 7-0. Entry 3 holds the read-ahead enable in bit 7 and count bits 9-8 in bits 1-0. Both are visible on the outputs.
- R7: Writing entry 3 with bit 6 set raises that channel's FIFO-clear output for exactly the one following cycle.
- R8: Index 7 reads as zero, and writes to it change no output.
- R9: 16-bit entries (0 and 4) take byte lane 0 from io_be[0] and byte lane 1 from io_be[1]. 8-bit entries take only lane 0 and are not written when io_be[0] is 0.
- R10: A pointer write takes effect only when io_be[0] is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 2 | Port offset (0 data, 1 pointer) |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_be | input | 2 | Byte enables |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, valid while io_rd is high |
| ptr_autoinc | output | 1 | Pointer auto-increment bit |
| ptr_post_ws | output | 1 | Posted-write wait-state bit |
| ptr_burst_dis | output | 1 | Burst disable bit |
| ptr_devsel_med | output | 1 | Medium select timing bit |
| ptr_chan | output | 1 | Selected channel |
| ptr_idx | output | 3 | Selected index |
| cmd_base_o | output | 32 | Command base per channel, channel 0 in bits 15-0 |
| gen_cfg_o | output | 16 | General config per channel |
| ra_count_o | output | 20 | Read-ahead count per channel, 10 bits each |
| ra_en_o | output | 2 | Read-ahead enable per channel |
| fifo_clr_o | output | 2 | One-cycle FIFO-clear pulse per channel |
| ctl_base_o | output | 32 | Control base per channel |
| data_tim_o | output | 16 | Data timing per channel |
| cmd_tim_o | output | 16 | Command timing per channel |

## Verification
The bench builds the block with its default parameters: 16-bit data, seven entries per bank, and the per-channel reset values above. With these defaults the full auto-increment walk and its wrap are within reach of a short pointer sequence. The same holds for the split byte lanes of the two 16-bit base entries and the write-only pulse path on the second channel. Streaming reads through a whole bank with auto-increment checks the decode, the reset values and the index stepping together.

// File: rtl/cfgfe_pkg.sv
package cfgfe_pkg;
  localparam int IDX_W = 3;

  typedef enum logic [IDX_W-1:0] {
    IX_CMD   = 3'd0,
    IX_GEN   = 3'd1,
    IX_RALO  = 3'd2,
    IX_RACFG = 3'd3,
    IX_CTL   = 3'd4,
    IX_DTIM  = 3'd5,
    IX_CTIM  = 3'd6,
    IX_NONE  = 3'd7
  } cfg_idx_e;

  typedef struct packed {
    logic             autoinc;
    logic             post_ws;
    logic             burst_dis;
    logic             devsel_med;
    logic             chan;
    logic [IDX_W-1:0] idx;
  } ptr_t;
endpackage

// File: rtl/cfgfe_ptr.sv
module cfgfe_ptr
  import cfgfe_pkg::*;
#(
  parameter int          LAST_IDX = 6,
  parameter logic [7:0]  RST_BYTE = 8'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       step,
  output ptr_t       ptr_q
);
  ptr_t ptr_d;
  logic ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (wr_en) begin
      ptr_d  = ptr_t'(wdata);
      ptr_en = 1'b1;
    end else if (step && ptr_q.autoinc) begin
      ptr_en = 1'b1;
      if (int'(ptr_q.idx) >= LAST_IDX) ptr_d.idx = '0;
      else                              ptr_d.idx = ptr_q.idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= ptr_t'(RST_BYTE);
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/cfgfe_bank.sv
module cfgfe_bank
  import cfgfe_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                RA_W     = 10,
  parameter logic [DATA_W-1:0] CMD_RST  = 16'h01F0,
  parameter logic [DATA_W-1:0] CTL_RST  = 16'h03F6,
  parameter logic [7:0]        GEN_RST  = 8'h01,
  parameter logic [7:0]        DTIM_RST = 8'hF5,
  parameter logic [7:0]        CTIM_RST = 8'hDE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  cfg_idx_e            idx,
  input  logic [1:0]          be,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [DATA_W-1:0]   cmd_base,
  output logic [DATA_W-1:0]   ctl_base,
  output logic [7:0]          gen_cfg,
  output logic [RA_W-1:0]     ra_count,
  output logic                ra_en,
  output logic                fifo_clr,
  output logic [7:0]          data_tim,
  output logic [7:0]          cmd_tim
);
  localparam int HI_W = RA_W - 8;

  logic              wr16, wr8;
  logic              en_cmd, en_ctl, en_gen, en_ralo, en_racfg, en_dtim, en_ctim;
  logic [DATA_W-1:0] cmd_d, ctl_d;
  logic              fifo_clr_d;
  logic [7:0]        ra_lo_q;
  logic [HI_W-1:0]   ra_hi_q;

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                              input logic [DATA_W-1:0] nw,
                                              input logic [1:0]        lanes);
    logic [DATA_W-1:0] r;
    r = old;
    if (lanes[0]) r[7:0]        = nw[7:0];
    if (lanes[1]) r[DATA_W-1:8] = nw[DATA_W-1:8];
    return r;
  endfunction

  always_comb begin
    wr16       = wr && (be != 2'b00);
    wr8        = wr && be[0];
    en_cmd     = wr16 && (idx == IX_CMD);
    en_ctl     = wr16 && (idx == IX_CTL);
    en_gen     = wr8  && (idx == IX_GEN);
    en_ralo    = wr8  && (idx == IX_RALO);
    en_racfg   = wr8  && (idx == IX_RACFG);
    en_dtim    = wr8  && (idx == IX_DTIM);
    en_ctim    = wr8  && (idx == IX_CTIM);
    cmd_d      = merge(cmd_base, wdata, be);
    ctl_d      = merge(ctl_base, wdata, be);
    fifo_clr_d = en_racfg && wdata[6];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_base <= CMD_RST;
      ctl_base <= CTL_RST;
      gen_cfg  <= GEN_RST;
      ra_lo_q  <= '0;
      ra_hi_q  <= '0;
      ra_en    <= 1'b0;
      data_tim <= DTIM_RST;
      cmd_tim  <= CTIM_RST;
      fifo_clr <= 1'b0;
    end else begin
      if (en_cmd)  cmd_base <= cmd_d;
      if (en_ctl)  ctl_base <= ctl_d;
      if (en_gen)  gen_cfg  <= wdata[7:0];
      if (en_ralo) ra_lo_q  <= wdata[7:0];
      if (en_racfg) begin
        ra_en   <= wdata[7];
        ra_hi_q <= wdata[HI_W-1:0];
      end
      if (en_dtim) data_tim <= wdata[7:0];
      if (en_ctim) cmd_tim  <= wdata[7:0];
      fifo_clr <= fifo_clr_d;
    end
  end

  assign ra_count = {ra_hi_q, ra_lo_q};

  always_comb begin
    case (idx)
      IX_CMD:  rdata = cmd_base;
      IX_GEN:  rdata = {{(DATA_W-8){1'b0}}, gen_cfg};
      IX_CTL:  rdata = ctl_base;
      IX_DTIM: rdata = {{(DATA_W-8){1'b0}}, data_tim};
      IX_CTIM: rdata = {{(DATA_W-8){1'b0}}, cmd_tim};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfgfe_top.sv
module cfgfe_top
  import cfgfe_pkg::*;
#(
  parameter int          DATA_W       = 16,
  parameter int          ADDR_W       = 2,
  parameter int          RA_W         = 10,
  parameter int          NUM_IDX      = 7,
  parameter logic [7:0]  PTR_RST      = 8'h50,
  parameter logic [15:0] CH0_CMD_BASE = 16'h01F0,
  parameter logic [15:0] CH1_CMD_BASE = 16'h0170,
  parameter logic [15:0] CH0_CTL_BASE = 16'h03F6,
  parameter logic [15:0] CH1_CTL_BASE = 16'h0376,
  parameter logic [7:0]  GEN_RST      = 8'h01,
  parameter logic [7:0]  DTIM_RST     = 8'hF5,
  parameter logic [7:0]  CTIM_RST     = 8'hDE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic [1:0]             io_be,
  input  logic [DATA_W-1:0]      io_wdata,
  output logic [DATA_W-1:0]      io_rdata,
  output logic                   ptr_autoinc,
  output logic                   ptr_post_ws,
  output logic                   ptr_burst_dis,
  output logic                   ptr_devsel_med,
  output logic                   ptr_chan,
  output logic [2:0]             ptr_idx,
  output logic [2*DATA_W-1:0]    cmd_base_o,
  output logic [15:0]            gen_cfg_o,
  output logic [2*RA_W-1:0]      ra_count_o,
  output logic [1:0]             ra_en_o,
  output logic [1:0]             fifo_clr_o,
  output logic [2*DATA_W-1:0]    ctl_base_o,
  output logic [15:0]            data_tim_o,
  output logic [15:0]            cmd_tim_o
);
  localparam int NCH       = 2;
  localparam int LAST_IDX  = NUM_IDX - 1;
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_PTR  = ADDR_W'(1);

  ptr_t              ptr_q;
  logic              ptr_wr, data_acc, data_wr;
  logic [DATA_W-1:0] bank_rdata [NCH];

  always_comb begin
    ptr_wr   = io_wr && (io_addr == OFS_PTR) && io_be[0];
    data_acc = (io_wr || io_rd) && (io_addr == OFS_DATA);
    data_wr  = io_wr && (io_addr == OFS_DATA);
  end

  cfgfe_ptr #(.LAST_IDX(LAST_IDX), .RST_BYTE(PTR_RST)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ptr_wr),
    .wdata (io_wdata[7:0]),
    .step  (data_acc),
    .ptr_q (ptr_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_bank
    localparam logic [DATA_W-1:0] CMD_R = (c == 0) ? CH0_CMD_BASE : CH1_CMD_BASE;
    localparam logic [DATA_W-1:0] CTL_R = (c == 0) ? CH0_CTL_BASE : CH1_CTL_BASE;
    logic bank_wr;
    assign bank_wr = data_wr && (ptr_q.chan == 1'(c));

    cfgfe_bank #(
      .DATA_W(DATA_W), .RA_W(RA_W), .CMD_RST(CMD_R), .CTL_RST(CTL_R),
      .GEN_RST(GEN_RST), .DTIM_RST(DTIM_RST), .CTIM_RST(CTIM_RST)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bank_wr),
      .idx      (cfg_idx_e'(ptr_q.idx)),
      .be       (io_be),
      .wdata    (io_wdata),
      .rdata    (bank_rdata[c]),
      .cmd_base (cmd_base_o[c*DATA_W +: DATA_W]),
      .ctl_base (ctl_base_o[c*DATA_W +: DATA_W]),
      .gen_cfg  (gen_cfg_o[c*8 +: 8]),
      .ra_count (ra_count_o[c*RA_W +: RA_W]),
      .ra_en    (ra_en_o[c]),
      .fifo_clr (fifo_clr_o[c]),
      .data_tim (data_tim_o[c*8 +: 8]),
      .cmd_tim  (cmd_tim_o[c*8 +: 8])
    );
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (io_addr == OFS_DATA)     io_rdata = bank_rdata[ptr_q.chan];
      else if (io_addr == OFS_PTR) io_rdata = {{(DATA_W-8){1'b0}}, ptr_q};
    end
  end

  assign ptr_autoinc    = ptr_q.autoinc;
  assign ptr_post_ws    = ptr_q.post_ws;
  assign ptr_burst_dis  = ptr_q.burst_dis;
  assign ptr_devsel_med = ptr_q.devsel_med;
  assign ptr_chan       = ptr_q.chan;
  assign ptr_idx        = ptr_q.idx;
endmodule

// File: rtl/cfgfe_chk.sv
module cfgfe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  io_addr,
  input logic        io_wr,
  input logic        io_rd,
  input logic [1:0]  io_be,
  input logic [15:0] io_wdata,
  input logic [15:0] io_rdata,
  input logic        ptr_autoinc,
  input logic        ptr_post_ws,
  input logic        ptr_burst_dis,
  input logic        ptr_devsel_med,
  input logic        ptr_chan,
  input logic [2:0]  ptr_idx,
  input logic [31:0] cmd_base_o,
  input logic [31:0] ctl_base_o,
  input logic [1:0]  fifo_clr_o
);
  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R1
  ptr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 2'd1) |->
      io_rdata == {8'h00, ptr_autoinc, ptr_post_ws, ptr_burst_dis,
                   ptr_devsel_med, ptr_chan, ptr_idx});

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && io_addr == 2'd0 && !ptr_autoinc) |=> $stable(ptr_idx));

  // R4
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || io_wr) && io_addr == 2'd0 && ptr_autoinc && ptr_idx >= 3'd6)
      |=> ptr_idx == 3'd0);

  // R6
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 2'd0 && (ptr_idx == 3'd2 || ptr_idx == 3'd3 || ptr_idx == 3'd7))
      |-> io_rdata == 16'h0000);

  // R7
  fifo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || !started)
    fifo_clr_o[0] |-> $past(io_wr && io_addr == 2'd0 && !ptr_chan && ptr_idx == 3'd3
                            && io_be[0] && io_wdata[6]));

  // R8
  idx7_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 2'd0 && ptr_idx == 3'd7)
      |=> ($stable(cmd_base_o) && $stable(ctl_base_o)));
endmodule

bind cfgfe_top cfgfe_chk chk_i (.*);

// File: tb/cfgfe_top_tb_top.sv
module cfgfe_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [1:0]  io_be = '0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic        ptr_autoinc, ptr_post_ws, ptr_burst_dis, ptr_devsel_med, ptr_chan;
  logic [2:0]  ptr_idx;
  logic [31:0] cmd_base_o, ctl_base_o;
  logic [15:0] gen_cfg_o, data_tim_o, cmd_tim_o;
  logic [19:0] ra_count_o;
  logic [1:0]  ra_en_o, fifo_clr_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  cfgfe_top dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data during each read cycle
  initial forever begin
    @(negedge clk); #5;
    if (io_rd && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {16'h0, io_rdata}, {16'h0, e});
    end
  end

  task automatic op(input logic [1:0] a, input logic w, input logic r,
                    input logic [1:0] be, input logic [15:0] d,
                    input logic [15:0] e, input string tag);
    @(negedge clk); #1;
    io_addr = a; io_wr = w; io_rd = r; io_be = be; io_wdata = d;
    if (r) begin exp_q.push_back(e); tag_q.push_back(tag); end
    @(negedge clk); #1;
    io_wr = 1'b0; io_rd = 1'b0; io_be = '0;
  endtask

  task automatic set_ptr(input logic [7:0] v);
    op(2'd1, 1'b1, 1'b0, 2'b01, {8'h00, v}, '0, "");
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tag);
    op(a, 1'b0, 1'b1, 2'b11, '0, e, tag);
  endtask

  task automatic wrd(input logic [1:0] be, input logic [15:0] d);
    op(2'd0, 1'b1, 1'b0, be, d, '0, "");
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #45 rst_n = 1'b1;
    #10;
    // R1 reset pointer and readback
    rd(2'd1, 16'h0050, "R1 ptr reset");
    #4;
    check("R1 ptr fields", {26'h0, ptr_post_ws, ptr_burst_dis, ptr_devsel_med, ptr_autoinc, ptr_chan, ptr_idx[0]}, 32'h28);
    // R5 defaults
    check("R5 cmd base", cmd_base_o, 32'h0170_01F0);
    check("R5 ctl base", ctl_base_o, 32'h0376_03F6);
    check("R5 gen", {16'h0, gen_cfg_o}, 32'h0101);
    check("R5 dtim", {16'h0, data_tim_o}, 32'hF5F5);
    check("R5 ctim", {16'h0, cmd_tim_o}, 32'hDEDE);
    check("R5 ra", {10'h0, ra_count_o, ra_en_o}, 32'h0);
    // R2 bank and index select
    set_ptr(8'h50); rd(2'd0, 16'h01F0, "R2 ch0 idx0");
    set_ptr(8'h58); rd(2'd0, 16'h0170, "R2 ch1 idx0");
    set_ptr(8'h5C); rd(2'd0, 16'h0376, "R2 ch1 idx4");
    // R3 / R4 streaming read with auto-increment
    set_ptr(8'hD0);
    rd(2'd0, 16'h01F0, "R3 walk0"); rd(2'd0, 16'h0001, "R3 walk1");
    rd(2'd0, 16'h0000, "R6 walk2"); rd(2'd0, 16'h0000, "R6 walk3");
    rd(2'd0, 16'h03F6, "R3 walk4"); rd(2'd0, 16'h00F5, "R3 walk5");
    rd(2'd0, 16'h00DE, "R3 walk6"); rd(2'd0, 16'h01F0, "R4 wrap");
    rd(2'd1, 16'h00D1, "R4 ptr after wrap");
    // R3 no increment when bit 7 clear
    set_ptr(8'h52); rd(2'd0, 16'h0000, "R6 idx2 read");
    rd(2'd1, 16'h0052, "R3 hold");
    // R6 / R7 write-only entries on channel 1
    set_ptr(8'h5A); wrd(2'b01, 16'h00AB);
    set_ptr(8'h5B); wrd(2'b01, 16'h00C2);
    #4;
    check("R7 pulse", {30'h0, fifo_clr_o}, 32'h2);
    @(negedge clk); #5;
    check("R7 pulse end", {30'h0, fifo_clr_o}, 32'h0);
    check("R6 ra count", {12'h0, ra_count_o}, {12'h0, 10'h2AB, 10'h000});
    check("R6 ra en", {30'h0, ra_en_o}, 32'h2);
    rd(2'd0, 16'h0000, "R6 idx3 read");
    // R8 index 7
    set_ptr(8'h57); wrd(2'b11, 16'hFFFF);
    #4;
    check("R8 cmd", cmd_base_o, 32'h0170_01F0);
    check("R8 ctl", ctl_base_o, 32'h0376_03F6);
    check("R8 gen/tim", {gen_cfg_o, data_tim_o}, 32'h0101_F5F5);
    check("R8 ctim", {16'h0, cmd_tim_o}, 32'hDEDE);
    rd(2'd0, 16'h0000, "R8 idx7 read");
    // R9 byte lanes
    set_ptr(8'h50); wrd(2'b10, 16'hABCD);
    #4; check("R9 hi lane", cmd_base_o, 32'h0170_ABF0);
    set_ptr(8'h55); wrd(2'b10, 16'h1234);
    #4; check("R9 8bit no lane0", {16'h0, data_tim_o}, 32'hF5F5);
    wrd(2'b01, 16'h1234);
    #4; check("R9 8bit lane0", {16'h0, data_tim_o}, 32'hF534);
    // R10 pointer write without lane 0
    op(2'd1, 1'b1, 1'b0, 2'b10, 16'h0000, '0, "");
    rd(2'd1, 16'h0055, "R10 ptr unchanged");
    // R4 wrap on write
    set_ptr(8'hD6); wrd(2'b01, 16'h0011);
    #4; check("R4 write idx6", {16'h0, cmd_tim_o}, 32'hDE11);
    rd(2'd1, 16'h00D0, "R4 wrap on write");
    @(negedge clk); @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule